// File: doc/BRIEF.md
# Raster-Operation Block Transfer Engine with Color Key

This block moves a rectangle of pixels inside video memory. Software, or a command sequencer, presents the following on a single start cycle:

- the source and destination byte addresses;
- a signed pitch for each region;
- the row width in bytes and the number of rows;
- a walk direction;
- a pixel size of 8 or 16 bits;
- a 4-bit raster-operation code;
- an optional two-byte transparency key.

The engine then walks both regions pixel by pixel. For each pixel it reads the source, reads the current destination and combines the two bitwise through the selected raster operation. It writes the result back unless transparency is on and the result equals the key.

Memory is reached through one request port with a valid/ready handshake, and read data returns on a separate valid strobe after a fixed latency. Every address is reduced by a video-memory address mask captured with the command, and 16-bit accesses are halfword aligned. A forward transfer of more than one row is refused at once if either pitch is smaller than the width. Such a transfer makes no memory access and still reports completion. A backward transfer is never refused.

Top module: `rop_blit_engine`

## Requirements
- R1: Forward walk. Both addresses rise by the pixel size (1 or 2) after each pixel. At the end of each row, each address then adds its own pitch minus the width.
- R2: Backward walk. Both addresses fall by the pixel size after each pixel. At the end of each row, each address then adds its own pitch plus the width.
- R3: A forward command with more than one row, where source pitch minus width or destination pitch minus width is negative, is refused:
  - `done` pulses in the cycle after `start`;
  - `busy` stays low;
  - no memory request is made.
  
  A backward command with the same values runs normally.
- R4: The written value is bit i of `cmd_rop` applied to each bit pair, where the index is i = 2*source_bit + destination_bit. For example, 4'hC copies the source, 4'hA keeps the destination, 4'h6 is XOR, 4'h8 is AND, 4'hE is OR, 4'h0 clears and 4'hF sets.
- R5: Each pixel is a source read, then a destination read, then the destination write, in that order. A new request is never issued while a read is outstanding.
- R6: With `cmd_key_en` set, the write is skipped when the result equals the key: `cmd_key_lo` for 8-bit pixels (`cmd_key_hi` ignored), or {`cmd_key_hi`,`cmd_key_lo`} for 16-bit pixels.
- R7: Every request address is the walk address ANDed with `cmd_addr_mask`. A 16-bit backward access uses the walk address minus one.
- R8: 16-bit pixels are little-endian. `mem_req_size` is 1 and bit 0 of the address is 0; data bits [7:0] belong to the even byte. 8-bit pixels use `mem_req_size` 0 and data bits [7:0], with bits [15:8] of the write data zero.
- R9: `start` while `busy` is ignored, and the running command completes unchanged.
- R10: After reset `busy`, `done` and `mem_req_valid` are low. `busy` rises the cycle after an accepted `start` and falls in the cycle `done` pulses for one cycle. A command with zero width or zero rows completes like a refused one.
- R11: A request held without `mem_req_ready` keeps its address, write flag and write data until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, sampled when idle |
| cmd_src_addr | input | AW (20) | Source start byte address |
| cmd_dst_addr | input | AW (20) | Destination start byte address |
| cmd_src_pitch | input | PW (16) | Signed source row pitch in bytes |
| cmd_dst_pitch | input | PW (16) | Signed destination row pitch in bytes |
| cmd_width | input | XW (12) | Row width in bytes, a multiple of the pixel size |
| cmd_height | input | YW (12) | Number of rows |
| cmd_backward | input | 1 | 1 walks addresses downward |
| cmd_pix16 | input | 1 | 1 selects 16-bit pixels, 0 selects 8-bit |
| cmd_rop | input | 4 | Raster-operation truth table |
| cmd_key_en | input | 1 | Enables transparency suppression |
| cmd_key_lo | input | 8 | Key low byte |
| cmd_key_hi | input | 8 | Key high byte (16-bit pixels only) |
| cmd_addr_mask | input | AW (20) | Video-memory address mask |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_size | output | 1 | 1 halfword, 0 byte |
| mem_req_addr | output | AW (20) | Request byte address |
| mem_req_wdata | output | 16 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
The bound assertions check the following on every cycle:

- requests are held stable while stalled;
- no request appears outside `busy` or while a read is outstanding;
- each address lies inside the captured mask, and 16-bit accesses are aligned and sized;
- no written value equals an enabled key;
- the command configuration is frozen when `start` arrives during `busy`.

Only the bench scenarios can show the rest:

- that the forward and backward walks, including the row-end pitch corrections, land on the right bytes;
- that each raster-operation code gives the right function;
- that skipped writes leave the destination as it was;
- that a refused command leaves memory untouched while the same values run backward.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int PIX_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RSRC  = 3'd1,
    ST_WSRC  = 3'd2,
    ST_RDST  = 3'd3,
    ST_WDST  = 3'd4,
    ST_WRITE = 3'd5
  } blit_state_e;
endpackage

// File: rtl/blit_rop_unit.sv
module blit_rop_unit #(
  parameter int DW = 16
) (
  input  logic [3:0]    code_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  output logic [DW-1:0] res_o
);
  // Each output bit looks up the truth table at index {source, destination}.
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign res_o[i] = code_i[{src_i[i], dst_i[i]}];
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int AW = 20,
  parameter int PW = 16,
  parameter int XW = 12,
  parameter int YW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [PW-1:0] spitch_i,
  input  logic [PW-1:0] dpitch_i,
  input  logic [XW-1:0] width_i,
  input  logic [YW-1:0] height_i,
  input  logic          bwd_i,
  input  logic          pix16_i,
  input  logic [AW-1:0] mask_i,
  output logic          pitch_bad_o,
  output logic [AW-1:0] src_acc_o,
  output logic [AW-1:0] dst_acc_o,
  output logic          last_o
);
  localparam int SW = PW + 2;
  localparam logic [AW-1:0] A_ONE = AW'(1);

  logic [AW-1:0] s_q, d_q, s_adj_q, d_adj_q;
  logic [AW-1:0] s_n, d_n, s_adj_n, d_adj_n;
  logic [XW-1:0] x_q, x_n, w_q;
  logic [YW-1:0] y_q, y_n, h_q;
  logic          bwd_q, p16_q;

  logic signed [SW-1:0] w_s, sp_s, dp_s, s_off, d_off;
  logic [AW-1:0] step_a, delta_a, s_pt, d_pt, align_m;
  logic [XW:0]   x_sum;
  logic [YW:0]   y_sum;
  logic          row_end;

  // Row corrections from the command fields, evaluated before the load.
  always_comb begin
    w_s   = $signed({{(SW-XW){1'b0}}, width_i});
    sp_s  = $signed({{2{spitch_i[PW-1]}}, spitch_i});
    dp_s  = $signed({{2{dpitch_i[PW-1]}}, dpitch_i});
    s_off = bwd_i ? (sp_s + w_s) : (sp_s - w_s);
    d_off = bwd_i ? (dp_s + w_s) : (dp_s - w_s);
    s_adj_n = {{(AW-SW){s_off[SW-1]}}, s_off};
    d_adj_n = {{(AW-SW){d_off[SW-1]}}, d_off};
    pitch_bad_o = ((sp_s - w_s) < 0) || ((dp_s - w_s) < 0);
  end

  // Per-pixel stepping.
  always_comb begin
    step_a  = {{(AW-2){1'b0}}, p16_q, ~p16_q};
    delta_a = bwd_q ? (~step_a + A_ONE) : step_a;
    x_sum   = {1'b0, x_q} + {{(XW-1){1'b0}}, p16_q, ~p16_q};
    row_end = (x_sum >= {1'b0, w_q});
    y_sum   = {1'b0, y_q} + {{YW{1'b0}}, 1'b1};
    last_o  = row_end && (y_sum == {1'b0, h_q});
    if (load_i) begin
      s_n = src_i;
      d_n = dst_i;
      x_n = '0;
      y_n = '0;
    end else begin
      s_n = s_q + delta_a + (row_end ? s_adj_q : '0);
      d_n = d_q + delta_a + (row_end ? d_adj_q : '0);
      x_n = row_end ? '0 : x_sum[XW-1:0];
      y_n = row_end ? y_sum[YW-1:0] : y_q;
    end
  end

  // Access addresses: backward halfwords reach down one byte, then mask and align.
  always_comb begin
    s_pt = (bwd_q && p16_q) ? (s_q - A_ONE) : s_q;
    d_pt = (bwd_q && p16_q) ? (d_q - A_ONE) : d_q;
    align_m   = ~{{(AW-1){1'b0}}, p16_q};
    src_acc_o = s_pt & mask_i & align_m;
    dst_acc_o = d_pt & mask_i & align_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0; d_q <= '0; x_q <= '0; y_q <= '0;
    end else if (load_i || adv_i) begin
      s_q <= s_n; d_q <= d_n; x_q <= x_n; y_q <= y_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_adj_q <= '0; d_adj_q <= '0; w_q <= '0; h_q <= '0;
      bwd_q <= 1'b0; p16_q <= 1'b0;
    end else if (load_i) begin
      s_adj_q <= s_adj_n; d_adj_q <= d_adj_n; w_q <= width_i; h_q <= height_i;
      bwd_q <= bwd_i; p16_q <= pix16_i;
    end
  end
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic reject_i,
  input  logic empty_i,
  input  logic ready_i,
  input  logic rvalid_i,
  input  logic skip_i,
  input  logic last_i,
  output logic req_valid_o,
  output logic req_we_o,
  output logic sel_dst_o,
  output logic load_o,
  output logic adv_o,
  output logic cap_src_o,
  output logic cap_dst_o,
  output logic busy_o,
  output logic done_o
);
  blit_state_e st_q, st_n;
  logic busy_q, busy_n, done_q, done_n;

  always_comb begin
    st_n = st_q; busy_n = busy_q; done_n = 1'b0;
    load_o = 1'b0; adv_o = 1'b0; cap_src_o = 1'b0; cap_dst_o = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        if (reject_i || empty_i) begin
          done_n = 1'b1;
        end else begin
          load_o = 1'b1; busy_n = 1'b1; st_n = ST_RSRC;
        end
      end
      ST_RSRC: if (ready_i) st_n = ST_WSRC;
      ST_WSRC: if (rvalid_i) begin cap_src_o = 1'b1; st_n = ST_RDST; end
      ST_RDST: if (ready_i) st_n = ST_WDST;
      ST_WDST: if (rvalid_i) begin cap_dst_o = 1'b1; st_n = ST_WRITE; end
      ST_WRITE: if (skip_i || ready_i) begin
        adv_o = 1'b1;
        if (last_i) begin
          st_n = ST_IDLE; busy_n = 1'b0; done_n = 1'b1;
        end else begin
          st_n = ST_RSRC;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    req_valid_o = (st_q == ST_RSRC) || (st_q == ST_RDST) || ((st_q == ST_WRITE) && !skip_i);
    req_we_o    = (st_q == ST_WRITE);
    sel_dst_o   = (st_q != ST_RSRC);
    busy_o      = busy_q;
    done_o      = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_n; busy_q <= busy_n; done_q <= done_n;
    end
  end
endmodule

// File: rtl/rop_blit_engine.sv
module rop_blit_engine #(
  parameter int AW = 20,
  parameter int PW = 16,
  parameter int XW = 12,
  parameter int YW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cmd_src_addr,
  input  logic [AW-1:0] cmd_dst_addr,
  input  logic [PW-1:0] cmd_src_pitch,
  input  logic [PW-1:0] cmd_dst_pitch,
  input  logic [XW-1:0] cmd_width,
  input  logic [YW-1:0] cmd_height,
  input  logic          cmd_backward,
  input  logic          cmd_pix16,
  input  logic [3:0]    cmd_rop,
  input  logic          cmd_key_en,
  input  logic [7:0]    cmd_key_lo,
  input  logic [7:0]    cmd_key_hi,
  input  logic [AW-1:0] cmd_addr_mask,
  output logic          busy,
  output logic          done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic          mem_req_size,
  output logic [AW-1:0] mem_req_addr,
  output logic [15:0]   mem_req_wdata,
  input  logic          mem_rvalid,
  input  logic [15:0]   mem_rdata
);
  import blit_pkg::*;

  logic [AW-1:0]    mask_q;
  logic [3:0]       rop_q;
  logic             key_en_q, pix16_q;
  logic [PIX_W-1:0] key_q, src_q, res_q, rd_pix, rop_res;
  logic             load, adv, cap_src, cap_dst, sel_dst, skip, last;
  logic             pitch_bad, reject, empty;
  logic [AW-1:0]    src_acc, dst_acc;

  always_comb begin
    reject = !cmd_backward && (cmd_height > YW'(1)) && pitch_bad;
    empty  = (cmd_width == '0) || (cmd_height == '0);
    rd_pix = pix16_q ? mem_rdata : {8'h00, mem_rdata[7:0]};
    skip   = key_en_q && (pix16_q ? (res_q == key_q) : (res_q[7:0] == key_q[7:0]));
    mem_req_addr  = sel_dst ? dst_acc : src_acc;
    mem_req_size  = pix16_q;
    mem_req_wdata = pix16_q ? res_q : {8'h00, res_q[7:0]};
  end

  blit_walker #(.AW(AW), .PW(PW), .XW(XW), .YW(YW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
    .src_i(cmd_src_addr), .dst_i(cmd_dst_addr),
    .spitch_i(cmd_src_pitch), .dpitch_i(cmd_dst_pitch),
    .width_i(cmd_width), .height_i(cmd_height),
    .bwd_i(cmd_backward), .pix16_i(cmd_pix16), .mask_i(mask_q),
    .pitch_bad_o(pitch_bad), .src_acc_o(src_acc), .dst_acc_o(dst_acc), .last_o(last)
  );

  blit_rop_unit #(.DW(PIX_W)) u_rop (
    .code_i(rop_q), .src_i(src_q), .dst_i(rd_pix), .res_o(rop_res)
  );

  blit_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .reject_i(reject), .empty_i(empty),
    .ready_i(mem_req_ready), .rvalid_i(mem_rvalid), .skip_i(skip), .last_i(last),
    .req_valid_o(mem_req_valid), .req_we_o(mem_req_we), .sel_dst_o(sel_dst),
    .load_o(load), .adv_o(adv), .cap_src_o(cap_src), .cap_dst_o(cap_dst),
    .busy_o(busy), .done_o(done)
  );

  // Command configuration, captured only when a command is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0; rop_q <= '0; key_en_q <= 1'b0; pix16_q <= 1'b0; key_q <= '0;
    end else if (load) begin
      mask_q <= cmd_addr_mask; rop_q <= cmd_rop; key_en_q <= cmd_key_en;
      pix16_q <= cmd_pix16; key_q <= {cmd_key_hi, cmd_key_lo};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else if (cap_src) src_q <= rd_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (cap_dst) res_q <= rop_res;
  end
endmodule

// File: rtl/blit_checker.sv
module blit_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic          mem_req_size,
  input logic [AW-1:0] mem_req_addr,
  input logic [15:0]   mem_req_wdata,
  input logic          mem_rvalid,
  input logic [AW-1:0] mask_q,
  input logic          pix16_q,
  input logic          key_en_q,
  input logic [15:0]   key_q,
  input logic [3:0]    rop_q
);
  logic [1:0] outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= '0;
    else if (mem_req_valid && mem_req_ready && !mem_req_we && !mem_rvalid) outst_q <= outst_q + 2'd1;
    else if (mem_rvalid && !(mem_req_valid && mem_req_ready && !mem_req_we)) outst_q <= outst_q - 2'd1;
  end

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  a_r10_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r5_one_read_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> outst_q == 2'd0);

  a_r7_addr_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr & ~mask_q) == '0);

  a_r8_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_size == pix16_q) && !(pix16_q && mem_req_addr[0]));

  a_r8_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && !pix16_q |-> mem_req_wdata[15:8] == 8'h00);

  a_r6_key_not_written: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && key_en_q |->
      (pix16_q ? (mem_req_wdata != key_q) : (mem_req_wdata[7:0] != key_q[7:0])));

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(rop_q) && $stable(key_q) && $stable(mask_q) && $stable(pix16_q));
endmodule

bind rop_blit_engine blit_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_size(mem_req_size), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_rvalid(mem_rvalid), .mask_q(mask_q), .pix16_q(pix16_q), .key_en_q(key_en_q),
  .key_q(key_q), .rop_q(rop_q)
);

// File: tb/sim_rop_blit_engine.sv
`timescale 1ns/1ps
module sim_rop_blit_engine;
  localparam int AW = 20, PW = 16, XW = 12, YW = 12;
  localparam int MSZ = 4096;

  logic clk, rst_n, start;
  logic busy, done, mem_req_valid, mem_req_ready, mem_req_we, mem_req_size, mem_rvalid;
  logic [AW-1:0] mem_req_addr;
  logic [15:0] mem_req_wdata, mem_rdata;

  int c_src, c_dst, c_sp, c_dp, c_w, c_h;
  bit c_bwd, c_p16, c_ken;
  logic [3:0] c_rop;
  logic [7:0] c_klo, c_khi;
  logic [AW-1:0] c_mask;

  logic [7:0] mem [MSZ];
  logic [7:0] refm [MSZ];
  bit fill_go, clr, stall_en;
  int fill_seed, nreq, ndone;
  logic [7:0] lfsr;
  logic v0, v1;
  logic [15:0] d0, d1;
  int n_chk, n_bad;
  bit finished;

  rop_blit_engine #(.AW(AW), .PW(PW), .XW(XW), .YW(YW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_src_addr(c_src[AW-1:0]), .cmd_dst_addr(c_dst[AW-1:0]),
    .cmd_src_pitch(c_sp[PW-1:0]), .cmd_dst_pitch(c_dp[PW-1:0]),
    .cmd_width(c_w[XW-1:0]), .cmd_height(c_h[YW-1:0]),
    .cmd_backward(c_bwd), .cmd_pix16(c_p16), .cmd_rop(c_rop), .cmd_key_en(c_ken),
    .cmd_key_lo(c_klo), .cmd_key_hi(c_khi), .cmd_addr_mask(c_mask),
    .busy(busy), .done(done), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_size(mem_req_size), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 37 + 11 + s * 13) & 255);
  endfunction

  // Memory model: byte array, little-endian halfwords, read latency of two cycles.
  always @(posedge clk) begin
    if (fill_go) for (int i = 0; i < MSZ; i++) mem[i] <= pat(i, fill_seed);
    if (!rst_n) begin
      v0 <= 1'b0; v1 <= 1'b0; d0 <= '0; d1 <= '0; lfsr <= 8'h5A; mem_req_ready <= 1'b1;
      nreq <= 0; ndone <= 0;
    end else begin
      v1 <= v0; d1 <= d0; v0 <= 1'b0;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready <= stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr[11:0]] <= mem_req_wdata[7:0];
          if (mem_req_size) mem[mem_req_addr[11:0] + 12'd1] <= mem_req_wdata[15:8];
        end else begin
          v0 <= 1'b1;
          d0 <= mem_req_size ? {mem[mem_req_addr[11:0] + 12'd1], mem[mem_req_addr[11:0]]}
                             : {8'h00, mem[mem_req_addr[11:0]]};
        end
      end
      if (clr) begin nreq <= 0; ndone <= 0; end
      else begin
        if (mem_req_valid && mem_req_ready) nreq <= nreq + 1;
        if (done) ndone <= ndone + 1;
      end
    end
  end
  assign mem_rvalid = v1;
  assign mem_rdata  = d1;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rop_f(logic [3:0] c, logic [15:0] s, logic [15:0] d);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = c[{s[i], d[i]}];
    return r;
  endfunction

  task automatic fill(int seed);
    @(negedge clk);
    fill_seed = seed; fill_go = 1'b1;
    @(negedge clk);
    fill_go = 1'b0;
    for (int i = 0; i < MSZ; i++) refm[i] = pat(i, seed);
  endtask

  // Independent model of the walk, written from the requirements.
  task automatic ref_blit(output int exp_req);
    int sa, da, st, as_, ad, m;
    logic [15:0] sv, dv, r;
    bit keep;
    exp_req = 0;
    if (!c_bwd && c_h > 1 && (c_sp - c_w < 0 || c_dp - c_w < 0)) return;
    st = c_p16 ? 2 : 1; sa = c_src; da = c_dst; m = int'(c_mask);
    for (int y = 0; y < c_h; y++) begin
      for (int x = 0; x < c_w; x += st) begin
        as_ = ((c_p16 && c_bwd) ? sa - 1 : sa) & m;
        ad  = ((c_p16 && c_bwd) ? da - 1 : da) & m;
        if (c_p16) begin as_ = as_ & ~1; ad = ad & ~1; end
        as_ = as_ & (MSZ - 1); ad = ad & (MSZ - 1);
        sv = c_p16 ? {refm[as_ + 1], refm[as_]} : {8'h00, refm[as_]};
        dv = c_p16 ? {refm[ad + 1], refm[ad]} : {8'h00, refm[ad]};
        r = rop_f(c_rop, sv, dv);
        if (!c_p16) r[15:8] = 8'h00;
        keep = c_ken && (c_p16 ? (r == {c_khi, c_klo}) : (r[7:0] == c_klo));
        exp_req += 2;
        if (!keep) begin
          exp_req++;
          refm[ad] = r[7:0];
          if (c_p16) refm[ad + 1] = r[15:8];
        end
        sa = c_bwd ? sa - st : sa + st;
        da = c_bwd ? da - st : da + st;
      end
      sa += c_bwd ? c_sp + c_w : c_sp - c_w;
      da += c_bwd ? c_dp + c_w : c_dp - c_w;
    end
  endtask

  task automatic mem_check(string rq);
    int bad = 0, first = -1;
    for (int i = 0; i < MSZ; i++) if (mem[i] !== refm[i]) begin
      bad++;
      if (first < 0) first = i;
    end
    chk(bad == 0, rq, $sformatf("memory bytes differing (first at %0d)", first), bad, 0);
  endtask

  task automatic setcmd(int s, int d, int sp, int dp, int w, int h, bit bw, bit p16,
                        logic [3:0] rop, bit ken, logic [7:0] klo, logic [7:0] khi);
    c_src = s; c_dst = d; c_sp = sp; c_dp = dp; c_w = w; c_h = h; c_bwd = bw; c_p16 = p16;
    c_rop = rop; c_ken = ken; c_klo = klo; c_khi = khi;
  endtask

  task automatic launch();
    @(negedge clk); start = 1'b1; clr = 1'b1;
    @(negedge clk); start = 1'b0; clr = 1'b0;
  endtask

  task automatic wait_done(output bit ok, output bit bz);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    ok = done; bz = busy;
  endtask

  // Run the current command and check completion, request count and memory.
  task automatic blit_check(string rq);
    int exp; bit ok, bz;
    ref_blit(exp);
    launch();
    wait_done(ok, bz);
    chk(ok, "R10", {rq, " done pulse seen"}, ok, 1);
    chk(!bz, "R10", {rq, " busy low with done"}, bz, 0);
    repeat (4) @(negedge clk);
    chk(nreq == exp, "R5", {rq, " accepted requests"}, nreq, exp);
    chk(ndone == 1, "R10", {rq, " done pulse count"}, ndone, 1);
    mem_check(rq);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R10", "busy after reset", busy, 0);
    chk(done == 1'b0, "R10", "done after reset", done, 0);
    chk(mem_req_valid == 1'b0, "R10", "request after reset", mem_req_valid, 0);
  endtask

  task automatic t_fwd8();
    fill(1);
    setcmd(256, 1024, 32, 40, 5, 4, 0, 0, 4'hC, 0, 8'h00, 8'h00);
    blit_check("R1 forward byte copy");
  endtask

  task automatic t_fwd8_stall();
    fill(2); stall_en = 1'b1;
    setcmd(300, 1100, 17, 23, 7, 3, 0, 0, 4'h6, 0, 8'h00, 8'h00);
    blit_check("R11 forward xor with stalls");
    stall_en = 1'b0;
  endtask

  task automatic t_bwd8();
    fill(3);
    setcmd(900, 1700, -24, -20, 6, 3, 1, 0, 4'hC, 0, 8'h00, 8'h00);
    blit_check("R2 backward byte copy");
  endtask

  task automatic t_key8();
    fill(4);
    setcmd(2048, 2304, 16, 16, 8, 3, 0, 0, 4'hC, 1, 8'h00, 8'hA5);
    c_klo = refm[2050];
    blit_check("R6 byte key, high byte ignored");
  endtask

  task automatic t_key16();
    fill(5); stall_en = 1'b1;
    setcmd(2560, 2816, 16, 20, 8, 3, 0, 1, 4'hC, 1, 8'h00, 8'h00);
    c_klo = refm[2562]; c_khi = refm[2563];
    blit_check("R8 halfword forward with key");
    stall_en = 1'b0;
  endtask

  task automatic t_bwd16();
    fill(6);
    setcmd(3087, 3343, -16, -18, 8, 3, 1, 1, 4'hE, 1, 8'h00, 8'h00);
    c_klo = refm[3084]; c_khi = refm[3085];
    blit_check("R7 halfword backward minus one");
  endtask

  task automatic t_reject();
    int exp; bit bz;
    fill(7);
    setcmd(400, 1200, 4, 32, 8, 3, 0, 0, 4'hC, 0, 8'h00, 8'h00);
    ref_blit(exp);
    launch();
    bz = busy;
    chk(done == 1'b1, "R3", "refused source pitch: done the cycle after start", done, 1);
    chk(!bz, "R3", "refused: busy stays low", bz, 0);
    repeat (4) @(negedge clk);
    chk(nreq == 0, "R3", "refused: requests", nreq, 0);
    mem_check("R3 refused source pitch leaves memory");
    setcmd(400, 1200, 32, -2, 8, 2, 0, 0, 4'hC, 0, 8'h00, 8'h00);
    launch();
    chk(done == 1'b1, "R3", "refused destination pitch: done", done, 1);
    repeat (4) @(negedge clk);
    chk(nreq == 0, "R3", "refused destination pitch: requests", nreq, 0);
    setcmd(400, 1200, 4, 4, 8, 1, 0, 0, 4'hC, 0, 8'h00, 8'h00);
    blit_check("R3 single row with small pitch runs");
    setcmd(600, 1500, 4, 4, 8, 3, 1, 0, 4'h6, 0, 8'h00, 8'h00);
    blit_check("R3 backward with small pitch runs");
  endtask

  task automatic t_busy_start();
    int exp; bit ok, bz;
    fill(8);
    setcmd(256, 1024, 16, 16, 6, 4, 0, 0, 4'hC, 0, 8'h00, 8'h00);
    ref_blit(exp);
    launch();
    repeat (6) @(negedge clk);
    setcmd(500, 1030, 16, 16, 6, 4, 0, 0, 4'hF, 0, 8'h00, 8'h00);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9", "still busy after ignored start", busy, 1);
    wait_done(ok, bz);
    chk(ok, "R9", "first command completes", ok, 1);
    repeat (6) @(negedge clk);
    chk(ndone == 1, "R9", "single done pulse", ndone, 1);
    chk(nreq == exp, "R9", "requests of first command only", nreq, exp);
    mem_check("R9 second start ignored");
  endtask

  task automatic t_mask();
    fill(9); c_mask = 20'h000FF;
    setcmd(496, 252, 32, 32, 8, 2, 0, 0, 4'hC, 0, 8'h00, 8'h00);
    blit_check("R7 address mask wraps");
    c_mask = 20'h00FFF;
  endtask

  task automatic t_empty();
    bit bz;
    fill(10);
    setcmd(256, 1024, 16, 16, 8, 0, 0, 0, 4'hC, 0, 8'h00, 8'h00);
    launch(); bz = busy;
    chk(done == 1'b1 && !bz, "R10", "zero rows completes at once", done, 1);
    setcmd(256, 1024, 16, 16, 0, 3, 1, 0, 4'hC, 0, 8'h00, 8'h00);
    launch();
    chk(done == 1'b1, "R10", "zero width completes at once", done, 1);
    repeat (4) @(negedge clk);
    chk(nreq == 0, "R10", "empty command requests", nreq, 0);
    mem_check("R10 empty command leaves memory");
  endtask

  task automatic t_rops();
    logic [3:0] codes [6] = '{4'h0, 4'h8, 4'hE, 4'hF, 4'hA, 4'h3};
    for (int k = 0; k < 6; k++) begin
      fill(11 + k);
      setcmd(128 + k * 8, 3600, 16, 16, 4, 2, 0, k[0], codes[k], 0, 8'h00, 8'h00);
      blit_check($sformatf("R4 rop code %0h", codes[k]));
    end
  endtask

  initial begin
    #900us;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; fill_go = 1'b0; clr = 1'b0; stall_en = 1'b0; fill_seed = 0;
    c_mask = 20'h00FFF;
    setcmd(0, 0, 0, 0, 0, 0, 0, 0, 4'h0, 0, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_fwd8();
    t_fwd8_stall();
    t_bwd8();
    t_key8();
    t_key16();
    t_bwd16();
    t_reject();
    t_busy_start();
    t_mask();
    t_empty();
    t_rops();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule